// File: doc/BRIEF.md
# Receive FIFO with Hysteretic Auto-RTS

This block buffers bytes coming out of a UART receiver and hands them to the CPU in arrival order. The receiver pushes a byte with a one-cycle write strobe. The CPU sees the oldest stored byte on `rd_data` at all times and removes it with a one-cycle read strobe. When the fill count reaches the selected trigger level, a receive interrupt request is raised. In FIFO mode the buffer holds 128 bytes. With FIFO mode off it behaves as a single holding register.

The active-low `rts_n` output tells the remote transmitter when to pause. With automatic flow control enabled, `rts_n` goes high at a threshold one level above the trigger. It returns low only after the buffer drains to a threshold one level below the trigger. Between the two thresholds it keeps its state. With automatic flow control disabled, `rts_n` follows a software request bit. The buffer keeps accepting bytes after `rts_n` goes high, up to the point where it is completely full. Writes that arrive when it is full are dropped and recorded in a sticky overrun flag.

Top module: `rx_fifo_autorts`

## Requirements
- R1: After reset, `fill` is 0, `empty` is 1, `rts_n` is 0, `rx_irq` is 0 and `overrun` is 0.
- R2: With `fifo_en`=1 the buffer stores up to 128 bytes. `rd_data` always shows the oldest stored byte, and each accepted read removes it. `full` is 1 exactly when `fill` equals the capacity.
- R3: A write while full with no read in the same cycle is dropped, and `overrun` becomes 1 on the next cycle. `overrun` stays 1 until a cycle with `stat_rd`=1 clears it. If a drop and `stat_rd` fall in the same cycle, `overrun` is 1 afterwards.
- R4: A read while empty is ignored: `fill` stays 0.
- R5: A read and a write in the same cycle while full are both performed, so `fill` stays at capacity and `overrun` is not set. A read and a write in the same cycle while empty store the byte and skip the read, so `fill` becomes 1.
- R6: `rx_irq` is 1 exactly when `fill` is at or above the trigger level. `trig_sel` values 0, 1, 2 and 3 select 8, 16, 24 and 28 bytes.
- R7: With `auto_rts_en`=1, `rts_n` goes to 1 on the cycle after `fill` reaches the off threshold. The off threshold is 16, 24, 28 and 28 for `trig_sel` 0, 1, 2 and 3.
- R8: With `auto_rts_en`=1, `rts_n` returns to 0 on the cycle after `fill` falls to or below the on threshold. The on threshold is 0, 8, 16 and 24 for `trig_sel` 0 to 3. Between the two thresholds `rts_n` keeps its previous value.
- R9: Writes are accepted while `rts_n` is 1, until the buffer is full.
- R10: With `auto_rts_en`=0, `rts_n` equals the inverse of `rts_req`, registered one cycle.
- R11: With `fifo_en`=0 the capacity is 1 byte and the trigger is 1 byte. Auto-RTS then turns off at 1 byte and back on at 0 bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en | input | 1 | 1 selects 128-byte FIFO mode, 0 selects single holding register |
| trig_sel | input | 2 | Trigger level select: 0=8, 1=16, 2=24, 3=28 |
| auto_rts_en | input | 1 | Enables hysteretic automatic RTS |
| rts_req | input | 1 | Software RTS request used when auto-RTS is off (1 drives `rts_n` low) |
| wr_en | input | 1 | Write strobe from the receiver |
| wr_data | input | 8 | Received byte |
| rd_en | input | 1 | CPU read strobe (pops the oldest byte) |
| stat_rd | input | 1 | Status read strobe, clears `overrun` |
| rd_data | output | 8 | Oldest stored byte |
| fill | output | 8 | Number of stored bytes |
| empty | output | 1 | Buffer holds no bytes |
| full | output | 1 | Buffer is at capacity |
| overrun | output | 1 | Sticky flag for dropped writes |
| rx_irq | output | 1 | Receive trigger interrupt request |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
A receiver push and a CPU pop can land in the same cycle. Which of the two takes effect then depends on the fill level. The bench provokes this at both boundaries, with the buffer completely full and with it empty. At full, both operations must happen: the count holds at 128 and no overrun is flagged. At empty, only the write happens and the count goes to 1. The later reads confirm that the byte order held across these collisions. A dropped write that coincides with a status read is also provoked, and the overrun flag must be set afterwards.

// File: rtl/rx_fifo_autorts.sv
module rx_fifo_autorts #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int LVL1  = 8,
  parameter int LVL2  = 16,
  parameter int LVL3  = 24,
  parameter int LVL4  = 28
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic [1:0]    trig_sel,
  input  logic          auto_rts_en,
  input  logic          rts_req,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic          stat_rd,
  output logic [DW-1:0] rd_data,
  output logic [$clog2(DEPTH+1)-1:0] fill,
  output logic          empty,
  output logic          full,
  output logic          overrun,
  output logic          rx_irq,
  output logic          rts_n
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt, cap, trig, off_lvl, on_lvl;
  logic          ovr_q, rts_off_q;

  always_comb begin
    if (!fifo_en) begin
      cap = CW'(1); trig = CW'(1); off_lvl = CW'(1); on_lvl = '0;
    end else begin
      cap = CW'(DEPTH);
      case (trig_sel)
        2'd0:    begin trig = CW'(LVL1); off_lvl = CW'(LVL2); on_lvl = '0;       end
        2'd1:    begin trig = CW'(LVL2); off_lvl = CW'(LVL3); on_lvl = CW'(LVL1); end
        2'd2:    begin trig = CW'(LVL3); off_lvl = CW'(LVL4); on_lvl = CW'(LVL2); end
        default: begin trig = CW'(LVL4); off_lvl = CW'(LVL4); on_lvl = CW'(LVL3); end
      endcase
    end
  end

  wire do_rd = rd_en && (cnt != '0);
  wire do_wr = wr_en && ((cnt < cap) || do_rd);
  wire drop  = wr_en && !do_wr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      cnt <= '0;
    end else begin
      if (do_wr) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ovr_q <= 1'b0;
    else if (drop)    ovr_q <= 1'b1;
    else if (stat_rd) ovr_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                rts_off_q <= 1'b0;
    else if (!auto_rts_en)     rts_off_q <= !rts_req;
    else if (cnt >= off_lvl)   rts_off_q <= 1'b1;
    else if (cnt <= on_lvl)    rts_off_q <= 1'b0;
  end

  assign rd_data = mem[rp];
  assign fill    = cnt;
  assign empty   = (cnt == '0);
  assign full    = (cnt >= cap);
  assign overrun = ovr_q;
  assign rx_irq  = (cnt >= trig);
  assign rts_n   = rts_off_q;
endmodule

module rx_fifo_autorts_chk #(
  parameter int DEPTH = 128,
  parameter int LVL2  = 16,
  parameter int LVL3  = 24
) (
  input logic clk,
  input logic rst_n,
  input logic fifo_en,
  input logic auto_rts_en,
  input logic rts_req,
  input logic wr_en,
  input logic rd_en,
  input logic stat_rd,
  input logic [$clog2(DEPTH+1)-1:0] fill,
  input logic empty,
  input logic full,
  input logic overrun,
  input logic rx_irq,
  input logic rts_n
);
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill) <= DEPTH);

  a_r3_drop_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    full && wr_en && !rd_en |=> $stable(fill) && overrun);

  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun && !stat_rd |=> overrun);

  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    empty && rd_en && !wr_en |=> fill == '0);

  a_r6_irq_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !empty);

  a_r7_rts_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $rose(rts_n) && $past(auto_rts_en) |->
      int'($past(fill)) >= ($past(fifo_en) ? LVL2 : 1));

  a_r8_rts_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $fell(rts_n) && $past(auto_rts_en) |->
      int'($past(fill)) <= ($past(fifo_en) ? LVL3 : 0));

  a_r10_manual_rts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(auto_rts_en) |-> rts_n == !$past(rts_req));
endmodule

bind rx_fifo_autorts rx_fifo_autorts_chk #(.DEPTH(DEPTH), .LVL2(LVL2), .LVL3(LVL3)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .auto_rts_en(auto_rts_en),
  .rts_req(rts_req), .wr_en(wr_en), .rd_en(rd_en), .stat_rd(stat_rd),
  .fill(fill), .empty(empty), .full(full), .overrun(overrun),
  .rx_irq(rx_irq), .rts_n(rts_n)
);

// File: tb/rx_fifo_autorts_bench.sv
module rx_fifo_autorts_bench;
  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, auto_rts_en = 1, rts_req = 1;
  logic [1:0] trig_sel = 0;
  logic wr_en = 0, rd_en = 0, stat_rd = 0;
  logic [7:0] wr_data = 0, rd_data, fill;
  logic empty, full, overrun, rx_irq, rts_n;

  int checks = 0, errors = 0;
  logic [7:0] q[$];
  logic [7:0] wseq = 8'h01;

  always #2.5 clk = ~clk;

  rx_fifo_autorts u_rx_fifo_autorts (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .trig_sel(trig_sel),
    .auto_rts_en(auto_rts_en), .rts_req(rts_req), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .stat_rd(stat_rd), .rd_data(rd_data),
    .fill(fill), .empty(empty), .full(full), .overrun(overrun),
    .rx_irq(rx_irq), .rts_n(rts_n)
  );

  // {trig_sel, fill, expected irq, expected rts_n}
  localparam int NV = 23;
  localparam logic [11:0] VEC [NV] = '{
    {2'd0, 8'd7, 1'b0, 1'b0}, {2'd0, 8'd8, 1'b1, 1'b0}, {2'd0, 8'd15, 1'b1, 1'b0},
    {2'd0, 8'd16, 1'b1, 1'b1}, {2'd0, 8'd7, 1'b0, 1'b1}, {2'd0, 8'd1, 1'b0, 1'b1},
    {2'd0, 8'd0, 1'b0, 1'b0},
    {2'd1, 8'd15, 1'b0, 1'b0}, {2'd1, 8'd16, 1'b1, 1'b0}, {2'd1, 8'd23, 1'b1, 1'b0},
    {2'd1, 8'd24, 1'b1, 1'b1}, {2'd1, 8'd9, 1'b0, 1'b1}, {2'd1, 8'd8, 1'b0, 1'b0},
    {2'd2, 8'd23, 1'b0, 1'b0}, {2'd2, 8'd24, 1'b1, 1'b0}, {2'd2, 8'd27, 1'b1, 1'b0},
    {2'd2, 8'd28, 1'b1, 1'b1}, {2'd2, 8'd17, 1'b0, 1'b1}, {2'd2, 8'd16, 1'b0, 1'b0},
    {2'd3, 8'd27, 1'b0, 1'b0}, {2'd3, 8'd28, 1'b1, 1'b1}, {2'd3, 8'd25, 1'b0, 1'b1},
    {2'd3, 8'd24, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock cycle of stimulus; starts and ends at a falling edge.
  task automatic cyc(input logic w, input logic r, input logic s);
    int cap;
    logic r_ok;
    cap = fifo_en ? 128 : 1;
    r_ok = r && (q.size() > 0);
    if (r_ok) check("R2 read order", rd_data, q[0]);
    wr_en = w; rd_en = r; stat_rd = s; wr_data = wseq;
    if (r_ok) void'(q.pop_front());
    if (w && (q.size() < cap)) q.push_back(wseq);
    if (w) wseq = wseq + 8'd1;
    @(negedge clk);
    wr_en = 0; rd_en = 0; stat_rd = 0;
  endtask

  task automatic set_fill(input int target);
    while (q.size() < target) cyc(1, 0, 0);
    while (q.size() > target) cyc(0, 1, 0);
    cyc(0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 fill", fill, 0); check("R1 empty", empty, 1);
    check("R1 rts_n", rts_n, 0); check("R1 irq", rx_irq, 0);
    check("R1 overrun", overrun, 0);
    rst_n = 1;
    @(negedge clk);

    // R6, R7, R8 threshold table
    for (int i = 0; i < NV; i++) begin
      trig_sel = VEC[i][11:10];
      set_fill(int'(VEC[i][9:2]));
      check("R6 fill", fill, VEC[i][9:2]);
      check("R6 irq", rx_irq, VEC[i][1]);
      check("R7/R8 rts_n", rts_n, VEC[i][0]);
    end

    // R2, R9: fill to capacity while RTS is off
    trig_sel = 0;
    set_fill(128);
    check("R2 fill", fill, 128); check("R2 full", full, 1);
    check("R9 rts_n", rts_n, 1); check("R9 overrun", overrun, 0);

    // R3 drop and overrun
    cyc(1, 0, 0);
    check("R3 fill", fill, 128); check("R3 overrun set", overrun, 1);
    cyc(0, 0, 0);
    check("R3 overrun sticky", overrun, 1);
    cyc(0, 0, 1);
    check("R3 overrun clear", overrun, 0);
    cyc(1, 0, 1);
    check("R3 set wins", overrun, 1);
    cyc(0, 0, 1);
    check("R3 clear again", overrun, 0);

    // R5 push and pop together while full
    cyc(1, 1, 0);
    check("R5 full fill", fill, 128); check("R5 no overrun", overrun, 0);

    set_fill(0);
    check("R2 empty", empty, 1); check("R8 rts_n on", rts_n, 0);

    // R4 read while empty
    cyc(0, 1, 0);
    check("R4 fill", fill, 0);
    // R5 push and pop together while empty
    cyc(1, 1, 0);
    check("R5 empty fill", fill, 1);
    cyc(0, 1, 0);
    check("R5 drained", fill, 0);

    // R10 manual RTS
    auto_rts_en = 0; rts_req = 0;
    cyc(0, 0, 0);
    check("R10 rts off", rts_n, 1);
    rts_req = 1;
    cyc(0, 0, 0);
    check("R10 rts on", rts_n, 0);
    auto_rts_en = 1;

    // R11 holding-register mode
    fifo_en = 0;
    cyc(1, 0, 0);
    check("R11 fill", fill, 1); check("R11 full", full, 1); check("R11 irq", rx_irq, 1);
    cyc(0, 0, 0);
    check("R11 rts off", rts_n, 1);
    cyc(1, 0, 0);
    check("R11 drop fill", fill, 1); check("R11 overrun", overrun, 1);
    cyc(0, 1, 1);
    check("R11 drained", fill, 0);
    cyc(0, 0, 0);
    check("R11 rts on", rts_n, 0); check("R11 overrun cleared", overrun, 0);
    fifo_en = 1;

    // R1 reset mid-run
    set_fill(20);
    rst_n = 0;
    @(negedge clk);
    q.delete();
    check("R1 reset fill", fill, 0); check("R1 reset rts_n", rts_n, 0);
    check("R1 reset irq", rx_irq, 0);
    rst_n = 1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule